// File: doc/BRIEF.md
# Instrument Status Reporting Registers

This block keeps the status state of a programmable instrument's remote-control port. Two sticky event registers collect single-cycle event pulses. The 8-bit event register is fed by the command parser, for example command errors and query errors. The 16-bit change register is fed by the instrument's internal operations as they complete. Each event register stays set until it is read or until a clear-status command arrives.

The event register is masked by its own enable register to form a summary bit in the status byte. The status byte is masked in two separate ways:
- The service-request enable produces the master summary bit and the service request line.
- The parallel-poll enable produces an individual status flag.

A simple register bus writes the three enable registers. It also reads every register. The read strobe doubles as the clearing strobe for the two event registers. Read data is combinational on the current state, and the clear takes effect at the clock edge that ends the read.

Register addresses (3 bits):

| Address | Register | Access |
|---|---|---|
| 0 | Event register | read, clears on read |
| 1 | Event enable | read/write |
| 2 | Status byte | live read |
| 3 | Service-request enable | read/write |
| 4 | Parallel-poll enable | read/write |
| 5 | Change register | read, clears on read |
| 6 | Individual flag | read, returns 0 or 1 in bit 0 |

Top module: `instr_status_regs`

## Requirements
- R1: After reset, the event register (address 0) reads 0x80. The event enable (1), service-request enable (3), parallel-poll enable (4) and change register (5) all read 0.
- R2: A read of address 0 returns the event register and then clears it. Bit 7 (power-on) is therefore seen only on the first read after reset.
- R3: A pulse on `evt_pulse[i]` sets event bit i, and the bit stays set. A command error (bit 5) sets the bit again on every new pulse, even if the register was read in between.
- R4: An event pulse in the same cycle as a clearing read, or as a clear-status, leaves its bit set after that cycle.
- R5: Status byte bit 5 is 1 exactly when (event register AND event enable) is non-zero.
- R6: Bit 6 of the service-request enable ignores writes and always reads back 0.
- R7: Status byte bit 6 and `srq` are both equal to the OR of (status byte AND service-request enable), with bit 6 left out of that OR.
- R8: `ind_flag` is the OR of (status byte AND parallel-poll enable). Address 6 returns it as 0 or 1.
- R9: Writing 0 to address 1, 3 or 4 clears that enable register.
- R10: A pulse on `chg_pulse[i]` sets bit i of the 16-bit change register. The bit stays set until a read of address 5 clears the register.
- R11: `clr_status` clears the event and change registers. It leaves all three enable registers unchanged.
- R12: Status byte bit 0 is 1 when the change register is non-zero. Bits 7 and 4..1 follow `sb_ext`. Bits 0, 5 and 6 of `sb_ext` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| evt_pulse | input | 8 | Event pulses into the event register |
| chg_pulse | input | 16 | Completion pulses into the change register |
| clr_status | input | 1 | Clear-status command strobe |
| sb_ext | input | 8 | External status byte summary bits (7, 4..1 used) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; clears event registers read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| srq | output | 1 | Service request line |
| mss | output | 1 | Master summary bit |
| ind_flag | output | 1 | Individual status flag |

## Verification
The bench builds the block with its default widths: an 8-bit event register and a 16-bit change register on a 16-bit data bus. With these widths, the top bit of the change register is reachable through the bus, and so are the 0x80 power-on value and the masked bit 6 of the service-request enable. It sets up collisions between event pulses and clearing reads, so that the no-loss rule is observed on the next read. It walks the status byte through states where only the enable masks decide whether `srq` and `ind_flag` are raised.

// File: rtl/instr_status_pkg.sv
package instr_status_pkg;

  localparam int ADDR_W  = 3;
  localparam int SB_W    = 8;
  localparam int ESB_POS = 5;
  localparam int MSS_POS = 6;
  localparam int CHG_POS = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_EVT    = 3'd0,
    A_EVT_EN = 3'd1,
    A_SBYTE  = 3'd2,
    A_SR_EN  = 3'd3,
    A_PP_EN  = 3'd4,
    A_CHG    = 3'd5,
    A_FLAG   = 3'd6
  } reg_addr_e;

  function automatic logic any_masked(input logic [SB_W-1:0] v,
                                      input logic [SB_W-1:0] m);
    return |(v & m);
  endfunction

endpackage

// File: rtl/instr_sticky_reg.sv
module instr_sticky_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);

  function automatic logic [W-1:0] next_val(input logic [W-1:0] cur,
                                            input logic [W-1:0] set,
                                            input logic         clr);
    return (clr ? '0 : cur) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= next_val(q_o, set_i, clr_i);
  end

  // R3, R4: a pulsed bit is set in the next cycle, whatever the clear did
  p_keep_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R2, R10: a clear with no pulse empties the register
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (q_o == '0));

  // R3: without clear, bits never drop
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));

endmodule

// File: rtl/instr_mask_reg.sv
module instr_mask_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] WR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i & WR_MASK;
  end

  // R6, R9: a write stores data with the fixed-zero bits removed
  p_write_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (q_o == ($past(d_i) & WR_MASK)));

  // R11: without a write the register holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o));

endmodule

// File: rtl/instr_summary.sv
module instr_summary
  import instr_status_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] evt_en_i,
  input  logic [SB_W-1:0]  sb_ext_i,
  input  logic             chg_any_i,
  input  logic [SB_W-1:0]  sr_en_i,
  input  logic [SB_W-1:0]  pp_en_i,
  output logic [SB_W-1:0]  sbyte_o,
  output logic             mss_o,
  output logic             flag_o
);

  localparam logic [SB_W-1:0] EXT_KEEP =
    ~((SB_W'(1) << ESB_POS) | (SB_W'(1) << MSS_POS) | (SB_W'(1) << CHG_POS));
  localparam logic [SB_W-1:0] NO_MSS = ~(SB_W'(1) << MSS_POS);

  logic             esb;
  logic [SB_W-1:0]  sb_low;

  assign esb = |(evt_i & evt_en_i);

  always_comb begin
    sb_low          = sb_ext_i & EXT_KEEP;
    sb_low[ESB_POS] = esb;
    sb_low[CHG_POS] = chg_any_i;
  end

  assign mss_o = any_masked(sb_low, sr_en_i & NO_MSS);

  always_comb begin
    sbyte_o          = sb_low;
    sbyte_o[MSS_POS] = mss_o;
  end

  assign flag_o = any_masked(sbyte_o, pp_en_i);

endmodule

// File: rtl/instr_status_regs.sv
module instr_status_regs
  import instr_status_pkg::*;
#(
  parameter int EVT_W   = 8,
  parameter int CHG_W   = 16,
  parameter int DATA_W  = 16,
  parameter int PON_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic [CHG_W-1:0]  chg_pulse,
  input  logic              clr_status,
  input  logic [SB_W-1:0]   sb_ext,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              srq,
  output logic              mss,
  output logic              ind_flag
);

  localparam logic [EVT_W-1:0] EVT_RST  = EVT_W'(1) << PON_BIT;
  localparam logic [SB_W-1:0]  SRE_MASK = ~(SB_W'(1) << MSS_POS);

  // named internal events for the assertions
  logic evt_rd_clr, chg_rd_clr, evt_clr, chg_clr;
  logic we_evt_en, we_sr_en, we_pp_en;

  logic [EVT_W-1:0] evt_q, evt_en_q;
  logic [CHG_W-1:0] chg_q;
  logic [SB_W-1:0]  sr_en_q, pp_en_q, sbyte;
  logic             chg_any;
  logic             unused_wdata;

  assign evt_rd_clr = bus_rd && (bus_addr == A_EVT);
  assign chg_rd_clr = bus_rd && (bus_addr == A_CHG);
  assign evt_clr    = evt_rd_clr || clr_status;
  assign chg_clr    = chg_rd_clr || clr_status;
  assign we_evt_en  = bus_wr && (bus_addr == A_EVT_EN);
  assign we_sr_en   = bus_wr && (bus_addr == A_SR_EN);
  assign we_pp_en   = bus_wr && (bus_addr == A_PP_EN);
  assign chg_any    = |chg_q;
  assign unused_wdata = ^bus_wdata[DATA_W-1:SB_W];

  instr_sticky_reg #(.W(EVT_W), .RST_VAL(EVT_RST)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(evt_pulse), .clr_i(evt_clr), .q_o(evt_q));

  instr_sticky_reg #(.W(CHG_W), .RST_VAL('0)) u_chg (
    .clk(clk), .rst_n(rst_n), .set_i(chg_pulse), .clr_i(chg_clr), .q_o(chg_q));

  instr_mask_reg #(.W(EVT_W), .WR_MASK('1)) u_evt_en (
    .clk(clk), .rst_n(rst_n), .we_i(we_evt_en),
    .d_i(bus_wdata[EVT_W-1:0]), .q_o(evt_en_q));

  instr_mask_reg #(.W(SB_W), .WR_MASK(SRE_MASK)) u_sr_en (
    .clk(clk), .rst_n(rst_n), .we_i(we_sr_en),
    .d_i(bus_wdata[SB_W-1:0]), .q_o(sr_en_q));

  instr_mask_reg #(.W(SB_W), .WR_MASK('1)) u_pp_en (
    .clk(clk), .rst_n(rst_n), .we_i(we_pp_en),
    .d_i(bus_wdata[SB_W-1:0]), .q_o(pp_en_q));

  instr_summary #(.EVT_W(EVT_W)) u_sum (
    .evt_i(evt_q), .evt_en_i(evt_en_q), .sb_ext_i(sb_ext),
    .chg_any_i(chg_any), .sr_en_i(sr_en_q), .pp_en_i(pp_en_q),
    .sbyte_o(sbyte), .mss_o(mss), .flag_o(ind_flag));

  assign srq = mss;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_EVT:    bus_rdata = DATA_W'(evt_q);
      A_EVT_EN: bus_rdata = DATA_W'(evt_en_q);
      A_SBYTE:  bus_rdata = DATA_W'(sbyte);
      A_SR_EN:  bus_rdata = DATA_W'(sr_en_q);
      A_PP_EN:  bus_rdata = DATA_W'(pp_en_q);
      A_CHG:    bus_rdata = DATA_W'(chg_q);
      A_FLAG:   bus_rdata = DATA_W'(ind_flag);
      default:  bus_rdata = '0;
    endcase
  end

  // R5: no enabled event bit, no event summary
  p_esb_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_en_q == '0) |-> !sbyte[ESB_POS]);

  // R7: service request needs an enable
  p_srq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_en_q == '0) |-> !srq);

  // R7: request line follows the status byte's bit 6
  p_srq_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srq == bus_rdata_sb6());

  // R8: flag needs a parallel-poll enable
  p_flag_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_en_q == '0) |-> !ind_flag);

  // R11: clear-status empties both event registers when no pulse races it
  p_clr_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && evt_pulse == '0 && chg_pulse == '0)
      |=> (evt_q == '0 && chg_q == '0));

  // R11: clear-status leaves the enables alone
  p_clr_keeps_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !bus_wr) |=> ($stable(evt_en_q) && $stable(sr_en_q) && $stable(pp_en_q)));

  function automatic logic bus_rdata_sb6();
    return sbyte[MSS_POS];
  endfunction

endmodule

// File: tb/sim_instr_status_regs.sv
`timescale 1ns/1ps
module sim_instr_status_regs;

  typedef struct {
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  evt_pulse = '0;
  logic [15:0] chg_pulse = '0;
  logic        clr_status = 0;
  logic [7:0]  sb_ext = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        srq, mss, ind_flag;

  int checks = 0, failures = 0;
  bit done = 0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  instr_status_regs u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .chg_pulse(chg_pulse),
    .clr_status(clr_status), .sb_ext(sb_ext), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .srq(srq), .mss(mss), .ind_flag(ind_flag));

  function automatic void check(logic [15:0] act, logic [15:0] exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endfunction

  // monitor: sample 2 ns before each rising edge
  initial forever begin
    @(negedge clk); #8;
    if (bus_rd) begin
      if (sb_q.size() == 0) check(16'hDEAD, 16'h0, "scoreboard-empty");
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(bus_rdata, it.exp, it.req);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string req,
                    input logic [7:0] ev = '0);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    bus_addr = a; bus_rd = 1; evt_pulse = ev;
    @(negedge clk);
    bus_rd = 0; evt_pulse = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic pulse(input logic [7:0] ev, input logic [15:0] cv, input logic clr);
    @(negedge clk);
    evt_pulse = ev; chg_pulse = cv; clr_status = clr;
    @(negedge clk);
    evt_pulse = '0; chg_pulse = '0; clr_status = 0;
  endtask

  task automatic chk_out(input logic act_sel, input logic exp, input string req);
    @(negedge clk); #8;
    check({15'd0, act_sel ? srq : ind_flag}, {15'd0, exp}, req);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1, R2: power-on bit once
    rd(3'd0, 16'h0080, "R1 event reset value");
    rd(3'd0, 16'h0000, "R2 power-on bit cleared by read");
    rd(3'd1, 16'h0000, "R1 event enable reset");
    rd(3'd3, 16'h0000, "R1 sr enable reset");
    rd(3'd4, 16'h0000, "R1 pp enable reset");
    rd(3'd5, 16'h0000, "R1 change reg reset");
    // R3: command error repeats
    pulse(8'h20, '0, 0);
    rd(3'd0, 16'h0020, "R3 command error set");
    pulse(8'h20, '0, 0);
    rd(3'd0, 16'h0020, "R3 command error set again");
    // R4: pulse on clearing read is kept
    rd(3'd0, 16'h0000, "R4 read during pulse shows old", 8'h04);
    rd(3'd0, 16'h0004, "R4 pulse survived clearing read");
    // R5
    wr(3'd1, 16'h0004);
    pulse(8'h04, '0, 0);
    rd(3'd2, 16'h0020, "R5 event summary bit");
    chk_out(1, 0, "R7 srq low without enable");
    // R6, R7
    wr(3'd3, 16'h00FF);
    rd(3'd3, 16'h00BF, "R6 sr enable bit6 fixed zero");
    rd(3'd2, 16'h0060, "R7 master summary in status byte");
    chk_out(1, 1, "R7 srq raised");
    // R8
    wr(3'd4, 16'h0040);
    rd(3'd6, 16'h0001, "R8 flag from bit6");
    chk_out(0, 1, "R8 ind_flag high");
    wr(3'd4, 16'h0001);
    rd(3'd6, 16'h0000, "R8 flag masked off");
    // R10, R12
    pulse('0, 16'h8001, 0);
    rd(3'd6, 16'h0001, "R8 flag from change summary");
    rd(3'd2, 16'h0061, "R12 change summary bit0");
    rd(3'd5, 16'h8001, "R10 change reg bits");
    rd(3'd5, 16'h0000, "R10 change reg cleared by read");
    @(negedge clk); sb_ext = 8'hFF;
    rd(3'd2, 16'h00FE, "R12 external bits, 0/5/6 ignored");
    @(negedge clk); sb_ext = 8'h00;
    // R11
    pulse('0, 16'h0002, 0);
    pulse('0, '0, 1);
    rd(3'd0, 16'h0000, "R11 event cleared");
    rd(3'd5, 16'h0000, "R11 change cleared");
    rd(3'd1, 16'h0004, "R11 event enable kept");
    rd(3'd3, 16'h00BF, "R11 sr enable kept");
    rd(3'd4, 16'h0001, "R11 pp enable kept");
    chk_out(1, 0, "R7 srq low after clear");
    // R4 with clear-status racing a pulse
    pulse(8'h04, '0, 1);
    rd(3'd0, 16'h0004, "R4 pulse survives clear-status");
    // R9
    wr(3'd1, 16'h0000);
    rd(3'd1, 16'h0000, "R9 event enable cleared");
    wr(3'd3, 16'h0000);
    rd(3'd3, 16'h0000, "R9 sr enable cleared");
    wr(3'd4, 16'h0000);
    rd(3'd4, 16'h0000, "R9 pp enable cleared");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) check(16'(sb_q.size()), 16'h0, "scoreboard-drain");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule